// File: doc/BRIEF.md
# Burst column address generator

This block produces the column address for every beat of one read or write burst in a synchronous DRAM. A command strobe loads a starting column together with an already decoded burst length code and an ordering flag. From the next cycle on, the block presents one column address per clock with a valid flag. It also raises a last-beat flag on the final beat of a fixed-length burst.

Two orderings are supported. Sequential ordering counts upward through the low bits of the column and wraps inside the aligned block the burst length defines. Interleaved ordering combines the low bits of the start column with the beat number by exclusive OR. A full-page burst steps through all columns of the row, wraps from the top column to zero, and runs until it is stopped. A stop input ends any burst, and a fresh command restarts the sequence in any cycle.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and before any command, `colValid` and `lastBeat` are 0.
- R2: In the cycle after an edge at which `cmdValid` is 1, `colValid` is 1 and `colAddr` equals the `startCol` sampled at that edge (beat 0).
- R3: `lenSel` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page, and the reserved codes 4, 5 and 6 give 1 beat. A fixed-length burst of L beats shows `colValid` for exactly L cycles, `lastBeat` is 1 only on beat L-1, and with no new command `colValid` is 0 in the following cycle.
- R4: With `burstIlv` = 0 and a fixed length L, beat k shows the start column with its low log2(L) bits replaced by (start low bits + k) mod L; the bits above are held.
- R5: With `burstIlv` = 1 and a fixed length L, beat k shows the start column with its low log2(L) bits XORed with k.
- R6: A full-page burst shows start + k mod 2^COL_W on beat k, so it wraps from column 511 to column 0 at the default width, never raises `lastBeat`, and keeps running until it is stopped or replaced.
- R7: A full-page request with `burstIlv` = 1 runs in sequential full-page order.
- R8: An edge with `burstStop` = 1 and `cmdValid` = 0 ends a running burst, so `colValid` and `lastBeat` are 0 in the next cycle. A stop while the block is idle has no effect.
- R9: `cmdValid` takes priority over `burstStop` and over a running burst. The new burst starts at beat 0 with its own start column, length and ordering in the next cycle.
- R10: `lenSel` and `burstIlv` are sampled only at a command edge. Changing them during a burst does not alter its addresses or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Read or write command: load a new burst |
| startCol | input | COL_W | Starting column of the new burst |
| lenSel | input | 3 | Decoded burst length code (see R3) |
| burstIlv | input | 1 | 1 selects interleaved order, 0 sequential |
| burstStop | input | 1 | Terminate the running burst |
| colAddr | output | COL_W | Column address of the current beat |
| colValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
The bench builds the block with its default column width of 9 bits, so a row has 512 columns. At this width a full-page burst can be followed across the wrap from 511 to 0 and beyond within a few hundred cycles. The start columns sit at awkward positions inside their aligned blocks, such as 501 or 0x0A3. This makes sequential wrap, interleaved XOR patterns and held upper bits visibly different from one another. Restart and stop are applied mid-burst, and a restart is applied together with a stop, so that the priority rule is exercised.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  localparam int LEN_W = 3;
  typedef logic [LEN_W-1:0] lenCode_t;

  localparam lenCode_t LEN_ONE   = 3'd0;
  localparam lenCode_t LEN_TWO   = 3'd1;
  localparam lenCode_t LEN_FOUR  = 3'd2;
  localparam lenCode_t LEN_EIGHT = 3'd3;
  localparam lenCode_t LEN_FULL  = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new burst
    logic step;     // advance to next beat
    logic fullSel;  // the burst being loaded is full page
  } bcgStrobes_t;
endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  lenCode_t         lenSel,
  input  logic             burstStop,
  output bcgStrobes_t      strobes,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] lowMask,
  output logic             colValid,
  output logic             lastBeat
);
  localparam logic [COL_W-1:0] MASK_ALL = '1;

  logic             active;
  logic             fullPage;
  logic [COL_W-1:0] newMask;
  logic             lastNow;

  always_comb begin
    unique case (lenSel)
      LEN_TWO:   newMask = COL_W'(1);
      LEN_FOUR:  newMask = COL_W'(3);
      LEN_EIGHT: newMask = COL_W'(7);
      LEN_FULL:  newMask = MASK_ALL;
      default:   newMask = '0;
    endcase
  end

  assign lastNow         = active && !fullPage && (beat == lowMask);
  assign strobes.load    = cmdValid;
  assign strobes.step    = active && !cmdValid && !burstStop && !lastNow;
  assign strobes.fullSel = (lenSel == LEN_FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      fullPage <= 1'b0;
      beat     <= '0;
      lowMask  <= '0;
    end else if (strobes.load) begin
      active   <= 1'b1;
      fullPage <= strobes.fullSel;
      beat     <= '0;
      lowMask  <= newMask;
    end else if (strobes.step) begin
      beat     <= beat + COL_W'(1);
    end else begin
      active   <= 1'b0;
    end
  end

  assign colValid = active;
  assign lastBeat = lastNow;

  AST_LOAD_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> colValid); // R2
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !cmdValid) |=> !colValid); // R3
  AST_STOP_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (burstStop && !cmdValid) |=> (!colValid && !lastBeat)); // R8
endmodule

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  bcgStrobes_t      strobes,
  input  logic [COL_W-1:0] startCol,
  input  logic             burstIlv,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] lowMask,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0] baseCol;
  logic             ilvMode;
  logic [COL_W-1:0] seqAddr;
  logic [COL_W-1:0] xorAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseCol <= '0;
      ilvMode <= 1'b0;
    end else if (strobes.load) begin
      baseCol <= startCol;
      ilvMode <= burstIlv && !strobes.fullSel;  // full page forces sequential
    end
  end

  // sequential: low bits count and wrap inside the aligned block
  assign seqAddr = (baseCol & ~lowMask) | ((baseCol + beat) & lowMask);
  // interleaved: low bits XOR beat index
  assign xorAddr = baseCol ^ (beat & lowMask);
  assign colAddr = ilvMode ? xorAddr : seqAddr;

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (colAddr == $past(startCol))); // R2
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> ((colAddr & ~lowMask) == ($past(colAddr) & ~lowMask))); // R4
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && (&lowMask)) |=> (colAddr == $past(colAddr) + COL_W'(1))); // R6
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenSel,
  input  logic             burstIlv,
  input  logic             burstStop,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             lastBeat
);
  bcgStrobes_t      strobes;
  logic [COL_W-1:0] beat;
  logic [COL_W-1:0] lowMask;

  bcg_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .lenSel    (lenSel),
    .burstStop (burstStop),
    .strobes   (strobes),
    .beat      (beat),
    .lowMask   (lowMask),
    .colValid  (colValid),
    .lastBeat  (lastBeat)
  );

  bcg_datapath #(.COL_W(COL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .startCol (startCol),
    .burstIlv (burstIlv),
    .beat     (beat),
    .lowMask  (lowMask),
    .colAddr  (colAddr)
  );
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  localparam int COLW = 9;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cmdValid = 1'b0;
  logic [COLW-1:0] startCol = '0;
  logic [2:0]      lenSel = 3'd0;
  logic            burstIlv = 1'b0;
  logic            burstStop = 1'b0;
  logic [COLW-1:0] colAddr;
  logic            colValid;
  logic            lastBeat;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .startCol(startCol),
    .lenSel(lenSel), .burstIlv(burstIlv), .burstStop(burstStop),
    .colAddr(colAddr), .colValid(colValid), .lastBeat(lastBeat)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(logic [2:0] len);
    case (len)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [COLW-1:0] expAddr(logic [COLW-1:0] s, logic [2:0] len,
                                              logic ilv, int k);
    logic [COLW-1:0] kk;
    logic [COLW-1:0] m;
    kk = COLW'(k);
    m  = COLW'(lenOf(len) - 1);
    if (len == 3'd7) return s + kk;
    if (ilv) return s ^ (kk & m);
    return (s & ~m) | ((s + kk) & m);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic startCmd(logic [COLW-1:0] col, logic [2:0] len, logic ilv);
    cmdValid = 1'b1; startCol = col; lenSel = len; burstIlv = ilv;
    tick();
    cmdValid = 1'b0;
  endtask

  task automatic checkBeats(string req, logic [COLW-1:0] col, logic [2:0] len, logic ilv);
    int n;
    n = lenOf(len);
    for (int k = 0; k < n; k++) begin
      check(req, "valid", colValid, 1);
      check(req, "addr", colAddr, expAddr(col, len, ilv, k));
      check(req, "last", lastBeat, (k == n - 1) ? 1 : 0);
      tick();
    end
    check(req, "valid after end", colValid, 0);
  endtask

  task automatic testReset();
    check("R1", "valid at reset", colValid, 0);
    check("R1", "last at reset", lastBeat, 0);
  endtask

  task automatic testSequential();
    startCmd(9'h1F5, 3'd3, 1'b0); checkBeats("R4", 9'h1F5, 3'd3, 1'b0);
    startCmd(9'h0C6, 3'd2, 1'b0); checkBeats("R4", 9'h0C6, 3'd2, 1'b0);
    startCmd(9'h13B, 3'd1, 1'b0); checkBeats("R3", 9'h13B, 3'd1, 1'b0);
    startCmd(9'h077, 3'd0, 1'b0); checkBeats("R3", 9'h077, 3'd0, 1'b0);
    startCmd(9'h055, 3'd5, 1'b0); checkBeats("R3", 9'h055, 3'd5, 1'b0);
  endtask

  task automatic testInterleaved();
    startCmd(9'h0A3, 3'd3, 1'b1); checkBeats("R5", 9'h0A3, 3'd3, 1'b1);
    startCmd(9'h1E6, 3'd2, 1'b1); checkBeats("R5", 9'h1E6, 3'd2, 1'b1);
    startCmd(9'h101, 3'd1, 1'b1); checkBeats("R5", 9'h101, 3'd1, 1'b1);
  endtask

  task automatic testFullPage(logic ilv, string req);
    startCmd(9'h1FE, 3'd7, ilv);
    for (int k = 0; k < 600; k++) begin
      check(req, "page addr", colAddr, 9'(9'h1FE + k));
      check(req, "page last", lastBeat, 0);
      tick();
    end
    burstStop = 1'b1;
    tick();
    burstStop = 1'b0;
    check("R8", "valid after page stop", colValid, 0);
    check("R8", "last after page stop", lastBeat, 0);
  endtask

  task automatic testStop();
    startCmd(9'h0C0, 3'd3, 1'b1);
    for (int k = 0; k < 3; k++) tick();
    check("R5", "addr before stop", colAddr, 9'h0C3);
    burstStop = 1'b1;
    tick();
    burstStop = 1'b0;
    check("R8", "valid after stop", colValid, 0);
    check("R8", "last after stop", lastBeat, 0);
    burstStop = 1'b1;
    tick(); tick();
    burstStop = 1'b0;
    check("R8", "idle stop valid", colValid, 0);
    startCmd(9'h022, 3'd1, 1'b0); checkBeats("R8", 9'h022, 3'd1, 1'b0);
  endtask

  task automatic testRestart();
    startCmd(9'h010, 3'd3, 1'b0);
    tick(); tick();
    check("R9", "addr before restart", colAddr, 9'h012);
    cmdValid = 1'b1; startCol = 9'h105; lenSel = 3'd2; burstIlv = 1'b0; burstStop = 1'b1;
    tick();
    cmdValid = 1'b0; burstStop = 1'b0;
    checkBeats("R9", 9'h105, 3'd2, 1'b0);
  endtask

  task automatic testModeHeld();
    startCmd(9'h033, 3'd2, 1'b0);
    lenSel = 3'd7; burstIlv = 1'b1;
    checkBeats("R10", 9'h033, 3'd2, 1'b0);
    lenSel = 3'd0; burstIlv = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    tick();
    testReset();
    testSequential();
    testInterleaved();
    testFullPage(1'b0, "R6");
    testFullPage(1'b1, "R7");
    testStop();
    testRestart();
    testModeHeld();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule